// File: doc/BRIEF.md
# Chip-Select Gated Duplicating Command Register

This block is a clocked register for the address, command and control lines of a memory bus. Each registered line is driven out on two copies with equal values, A and B, so that two loads each get their own driver. The 22 address and command lines are gated by chip select. The two active-low chip selects, the two clock-enable lines and the two on-die-termination lines are not gated and are registered on every rising edge.

A static mode input, `gate_en`, sets the power-saving behaviour. With `gate_en` HIGH, the gated lines load new values only on an edge where at least one chip select is LOW. When both chip selects are HIGH, those lines keep their last value. With `gate_en` LOW, every line loads on every rising edge. An active-low reset clears every register at once, with no clock edge needed. Release of the reset is passed through a short synchroniser, so the first capture after reset falls on a known edge.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: With `gate_en` = 0, `qa_d`/`qb_d` show the `d_in` value present at the most recent rising edge, whatever `cs_n` is.
- R2: With `gate_en` = 1 and at least one bit of `cs_n` LOW at a rising edge, `d_in` is captured at that edge.
- R3: With `gate_en` = 1 and `cs_n` all ones at a rising edge, `qa_d`/`qb_d` keep their previous value.
- R4: `q*_cs_n`, `q*_cke` and `q*_odt` show the `cs_n`, `cke_in` and `odt_in` values from the most recent rising edge, in both modes.
- R5: Every A output equals its B counterpart at every rising edge after reset.
- R6: While `rst_n` is LOW, every output is LOW. This takes effect without a clock edge and overrides chip-select activity.
- R7: After `rst_n` rises, outputs stay LOW through the first SYNC_STAGES (default 2) rising edges. The first capture happens on edge SYNC_STAGES+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases through the synchroniser |
| gate_en | input | 1 | 1 = gated lines load only when a chip select is active; 0 = load every edge |
| d_in | input | 22 | Chip-select-gated address and command lines |
| cs_n | input | 2 | Active-low chip selects |
| cke_in | input | 2 | Clock-enable lines, never gated |
| odt_in | input | 2 | Termination-control lines, never gated |
| qa_d | output | 22 | Copy A of the gated lines |
| qb_d | output | 22 | Copy B of the gated lines |
| qa_cs_n | output | 2 | Copy A of the chip selects |
| qb_cs_n | output | 2 | Copy B of the chip selects |
| qa_cke | output | 2 | Copy A of the clock enables |
| qb_cke | output | 2 | Copy B of the clock enables |
| qa_odt | output | 2 | Copy A of the termination lines |
| qb_odt | output | 2 | Copy B of the termination lines |

## Verification
The bench builds the block with its default values: 22 gated lines, two-bit chip-select, clock-enable and termination groups, a two-stage release synchroniser, and separate flop banks for each copy. With separate banks, the A/B equality check compares two independently clocked registers rather than one wire fanned out twice. The two-stage synchroniser makes the exact edge of the first capture after reset observable. Random traffic in both modes, biased towards both chip selects HIGH, keeps the hold path under steady use. Directed steps cover the four chip-select patterns in each mode and a reset dropped in the middle of traffic.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

   // Meaning of the static mode pin
   typedef enum logic {
      CAPTURE_ALWAYS    = 1'b0,
      CAPTURE_ON_SELECT = 1'b1
   } gate_mode_e;

   localparam int DEF_GATED_W    = 22;
   localparam int DEF_CS_W       = 2;
   localparam int DEF_CKE_W      = 2;
   localparam int DEF_ODT_W      = 2;
   localparam int DEF_SYNC_STAGE = 2;

endpackage

// File: rtl/cmdreg_rst_sync.sv
module cmdreg_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/cmdreg_cap_stage.sv
module cmdreg_cap_stage #(
   parameter int W        = 8,
   parameter bit DUP_REGS = 1'b1
) (
   input  logic         clk,
   input  logic         srst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] qa,
   output logic [W-1:0] qb
);
   if (DUP_REGS) begin : g_two_banks
      logic [W-1:0] bank_a, bank_b;
      always_ff @(posedge clk or negedge srst_n) begin
         if (!srst_n)   bank_a <= '0;
         else if (load) bank_a <= din;
      end
      always_ff @(posedge clk or negedge srst_n) begin
         if (!srst_n)   bank_b <= '0;
         else if (load) bank_b <= din;
      end
      assign qa = bank_a;
      assign qb = bank_b;
   end else begin : g_one_bank
      logic [W-1:0] bank;
      always_ff @(posedge clk or negedge srst_n) begin
         if (!srst_n)   bank <= '0;
         else if (load) bank <= din;
      end
      assign qa = bank;
      assign qb = bank;
   end
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
   import cmdreg_pkg::*;
#(
   parameter int GATED_W     = DEF_GATED_W,
   parameter int CS_W        = DEF_CS_W,
   parameter int CKE_W       = DEF_CKE_W,
   parameter int ODT_W       = DEF_ODT_W,
   parameter int SYNC_STAGES = DEF_SYNC_STAGE,
   parameter bit DUP_REGS    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate_en,
   input  logic [GATED_W-1:0] d_in,
   input  logic [CS_W-1:0]    cs_n,
   input  logic [CKE_W-1:0]   cke_in,
   input  logic [ODT_W-1:0]   odt_in,
   output logic [GATED_W-1:0] qa_d,
   output logic [GATED_W-1:0] qb_d,
   output logic [CS_W-1:0]    qa_cs_n,
   output logic [CS_W-1:0]    qb_cs_n,
   output logic [CKE_W-1:0]   qa_cke,
   output logic [CKE_W-1:0]   qb_cke,
   output logic [ODT_W-1:0]   qa_odt,
   output logic [ODT_W-1:0]   qb_odt
);
   localparam int CTRL_W = CS_W + CKE_W + ODT_W;

   // elaboration-time parameter checks
   if (GATED_W < 1) begin : g_bad_gated_w
      $error("GATED_W must be at least 1");
   end
   if (CS_W < 1) begin : g_bad_cs_w
      $error("CS_W must be at least 1");
   end
   if (CKE_W < 1 || ODT_W < 1) begin : g_bad_ctrl_w
      $error("CKE_W and ODT_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       srst_n;
   gate_mode_e mode;
   logic       any_selected;
   logic       gated_load;
   logic [CTRL_W-1:0] ctrl_in, ctrl_qa, ctrl_qb;

   cmdreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (clk),
      .arst_n (rst_n),
      .srst_n (srst_n)
   );

   assign mode         = gate_mode_e'(gate_en);
   assign any_selected = ~&cs_n;
   assign gated_load   = (mode == CAPTURE_ALWAYS) || any_selected;

   cmdreg_cap_stage #(.W(GATED_W), .DUP_REGS(DUP_REGS)) u_gated (
      .clk    (clk),
      .srst_n (srst_n),
      .load   (gated_load),
      .din    (d_in),
      .qa     (qa_d),
      .qb     (qb_d)
   );

   assign ctrl_in = {cs_n, cke_in, odt_in};

   cmdreg_cap_stage #(.W(CTRL_W), .DUP_REGS(DUP_REGS)) u_ctrl (
      .clk    (clk),
      .srst_n (srst_n),
      .load   (1'b1),
      .din    (ctrl_in),
      .qa     (ctrl_qa),
      .qb     (ctrl_qb)
   );

   assign {qa_cs_n, qa_cke, qa_odt} = ctrl_qa;
   assign {qb_cs_n, qb_cke, qb_odt} = ctrl_qb;
endmodule

// File: rtl/cmd_reg_chk.sv
module cmd_reg_chk #(
   parameter int GATED_W = 22,
   parameter int CS_W    = 2,
   parameter int CKE_W   = 2,
   parameter int ODT_W   = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               srst_n,
   input logic               gate_en,
   input logic [GATED_W-1:0] d_in,
   input logic [CS_W-1:0]    cs_n,
   input logic [CKE_W-1:0]   cke_in,
   input logic [ODT_W-1:0]   odt_in,
   input logic [GATED_W-1:0] qa_d,
   input logic [GATED_W-1:0] qb_d,
   input logic [CS_W-1:0]    qa_cs_n,
   input logic [CS_W-1:0]    qb_cs_n,
   input logic [CKE_W-1:0]   qa_cke,
   input logic [CKE_W-1:0]   qb_cke,
   input logic [ODT_W-1:0]   qa_odt,
   input logic [ODT_W-1:0]   qb_odt
);
   // R1
   always_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_n && !gate_en) |=> (qa_d == $past(d_in)));

   // R2
   selected_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (srst_n && gate_en && !(&cs_n)) |=> (qa_d == $past(d_in)));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_en && (&cs_n)) |=> $stable(qa_d));

   // R4
   ctrl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_n |=> ({qa_cs_n, qa_cke, qa_odt} == $past({cs_n, cke_in, odt_in})));

   // R5
   copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qa_d == qb_d) && (qa_cs_n == qb_cs_n) && (qa_cke == qb_cke) && (qa_odt == qb_odt));

   // R6
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (qa_d == '0 && qb_d == '0 && qa_cs_n == '0 && qb_cs_n == '0
                  && qa_cke == '0 && qb_cke == '0 && qa_odt == '0 && qb_odt == '0));

   // R7
   release_quiet_chk: assert property (@(posedge clk)
      !$past(rst_n) |-> (qa_d == '0 && qa_cs_n == '0 && qa_cke == '0 && qa_odt == '0));
endmodule

bind cs_gated_cmd_reg cmd_reg_chk #(
   .GATED_W (GATED_W),
   .CS_W    (CS_W),
   .CKE_W   (CKE_W),
   .ODT_W   (ODT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .srst_n  (srst_n),
   .gate_en (gate_en),
   .d_in    (d_in),
   .cs_n    (cs_n),
   .cke_in  (cke_in),
   .odt_in  (odt_in),
   .qa_d    (qa_d),
   .qb_d    (qb_d),
   .qa_cs_n (qa_cs_n),
   .qb_cs_n (qb_cs_n),
   .qa_cke  (qa_cke),
   .qb_cke  (qb_cke),
   .qa_odt  (qa_odt),
   .qb_odt  (qb_odt)
);

// File: tb/cs_gated_cmd_reg_test.sv
module cs_gated_cmd_reg_test;
   localparam int GW = 22;
   localparam int CW = 2;
   localparam int KW = 2;
   localparam int OW = 2;
   localparam int SS = 2;
   localparam int XW = CW + KW + OW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n   = 1'b1;
   logic          gate_en = 1'b0;
   logic [GW-1:0] d_in    = '0;
   logic [CW-1:0] cs_n    = '1;
   logic [KW-1:0] cke_in  = '0;
   logic [OW-1:0] odt_in  = '0;
   logic [GW-1:0] qa_d, qb_d;
   logic [CW-1:0] qa_cs_n, qb_cs_n;
   logic [KW-1:0] qa_cke, qb_cke;
   logic [OW-1:0] qa_odt, qb_odt;

   cs_gated_cmd_reg uut (
      .clk(clk), .rst_n(rst_n), .gate_en(gate_en), .d_in(d_in), .cs_n(cs_n),
      .cke_in(cke_in), .odt_in(odt_in), .qa_d(qa_d), .qb_d(qb_d),
      .qa_cs_n(qa_cs_n), .qb_cs_n(qb_cs_n), .qa_cke(qa_cke), .qb_cke(qb_cke),
      .qa_odt(qa_odt), .qb_odt(qb_odt)
   );

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   int rel_edges = 0;
   logic [GW-1:0] m_d = '0;
   logic [XW-1:0] m_x = '0;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic loads(logic ge, logic [CW-1:0] cs);
      return !ge || (cs != '1);
   endfunction

   task automatic compare_all(string tag_d, string tag_x);
      check(tag_d, 32'(qa_d), 32'(m_d));
      check("R5",  32'(qb_d), 32'(m_d));
      check(tag_x, 32'({qa_cs_n, qa_cke, qa_odt}), 32'(m_x));
      check("R5",  32'({qb_cs_n, qb_cke, qb_odt}), 32'(m_x));
   endtask

   // apply one vector, pass one rising edge, update the model, compare
   task automatic step(logic ge, logic [GW-1:0] d, logic [CW-1:0] cs,
                       logic [KW-1:0] ck, logic [OW-1:0] od);
      string td, tx;
      gate_en = ge; d_in = d; cs_n = cs; cke_in = ck; odt_in = od;
      @(posedge clk);
      #1;
      if (!rst_n) begin
         m_d = '0; m_x = '0; td = "R6"; tx = "R6";
      end else begin
         rel_edges++;
         if (rel_edges > SS) begin
            m_x = {cs, ck, od};
            if (loads(ge, cs)) m_d = d;
            td = !ge ? "R1" : (cs != '1) ? "R2" : "R3";
            tx = "R4";
         end else begin
            td = "R7"; tx = "R7";
         end
      end
      compare_all(td, tx);
   endtask

   function automatic logic [GW-1:0] rnd_d();
      return GW'($urandom);
   endfunction

   function automatic logic [CW-1:0] rnd_cs();
      return ($urandom_range(9) < 4) ? '1 : CW'($urandom);
   endfunction

   task automatic mid_reset();
      rst_n = 1'b0;
      #1;
      m_d = '0; m_x = '0; rel_edges = 0;
      compare_all("R6", "R6"); // cleared before any clock edge
      for (int i = 0; i < 3; i++) step(1'b1, rnd_d(), '0, '1, '1); // R6 over active select
      #0 rst_n = 1'b1;
      for (int i = 0; i < SS; i++) step(1'b0, '1, '0, '1, '1);      // R7 quiet window
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd4242));
      #1 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      compare_all("R6", "R6");
      rst_n = 1'b1;
      rel_edges = 0;
      // R7: inputs busy but outputs must stay low for SS edges
      for (int i = 0; i < SS; i++) step(1'b0, 22'h2AAAAA, '0, '1, '1);
      step(1'b0, 22'h155555, 2'b10, 2'b01, 2'b10); // R7: first capture edge
      // all chip-select patterns in both modes
      for (int m = 0; m < 2; m++)
         for (int c = 0; c < 4; c++)
            step(m[0], rnd_d(), CW'(c), KW'(c), OW'(3 - c));
      // R3: long idle run in gating mode with changing data
      for (int i = 0; i < 5; i++) step(1'b1, rnd_d(), '1, KW'(i), OW'(i));
      // random traffic with occasional resets
      for (int i = 0; i < 3000; i++) begin
         if (i % 700 == 350) mid_reset();
         else step(($urandom_range(3) != 0) ? 1'b1 : 1'b0, rnd_d(), rnd_cs(),
                   KW'($urandom), OW'($urandom));
      end
      finished = 1'b1;
      finish_run();
   end
endmodule